// File: doc/BRIEF.md
# Software-Refilled Set-Associative Translation Buffer

This block turns virtual addresses into physical addresses by searching a two-way set-associative buffer of page mappings. A requester presents a virtual address with a strobe and a read/write flag. One cycle later the block reports exactly one of three outcomes: a hit carrying the physical address, a miss, or a protection fault. The address is split into a page offset, which is not translated, and a virtual page number. The low bits of the page number choose a set, and the remaining bits are compared against the stored tags of both ways.

A miss does not start any hardware walk. It only raises the miss outcome, and supervisor software is expected to fetch the mapping and install it through the install port. The install port picks the way by itself. Each entry keeps a valid bit, a dirty bit, a reference bit and a two-bit rights field. The reference bits steer which way is replaced. Software can drop all reference bits at once so that they record recent use only, and a flush input empties the whole buffer.

With the default parameters the virtual address is 40 bits, the physical address is 36 bits, pages are 16 KB (14 offset bits), and there are 128 sets of two ways. That gives a 7-bit set index, a 19-bit tag and a 22-bit physical page number.

Top module: `tlb_xlate`

## Requirements
- R1: One cycle after a strobe whose page number matches a valid entry and whose access is permitted, `res_hit` is high and `res_pa` equals the stored physical page number followed by the unchanged low OFS_W address bits. The set index is page-number bits [IDX_W-1:0], that is address bits [OFS_W+IDX_W-1:OFS_W], and the tag is the remaining upper bits.
- R2: One cycle after a strobe, `res_vld` is high and exactly one of `res_hit`, `res_miss`, `res_fault` is high. A lookup that matches no valid entry in its set gives `res_miss` with `res_pa` zero. Without a strobe, all four flags stay low.
- R3: Rights bit 0 permits reads (`lk_wr`=0) and rights bit 1 permits writes (`lk_wr`=1). A matching lookup whose access is not permitted gives `res_fault` with `res_pa` zero.
- R4: A permitted hit sets the reference bit of that entry. A faulting lookup leaves the reference bit unchanged.
- R5: A permitted write hit sets the entry's dirty bit. A faulting write does not. On a hit, `res_dirty` shows the dirty bit as it stood before that access, and it is zero for misses and faults.
- R6: An install goes to the way of the set that already holds the same page number. If no way holds it, the install goes to the lowest invalid way. If every way is valid, it goes to the lowest way whose reference bit is clear, and if none is clear it goes to way 0. The installed entry is valid, with its dirty and reference bits clear.
- R7: An install takes effect for lookups strobed in the next cycle. A lookup strobed in the same cycle as the install sees the previous contents.
- R8: `flush` invalidates every entry in one cycle. An install in the same cycle is discarded.
- R9: `clr_ref` clears every reference bit in one cycle. A permitted hit in the same cycle leaves its own entry's reference bit set.
- R10: After synchronous reset every entry is invalid and all result outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vld | input | 1 | Lookup strobe |
| lk_wr | input | 1 | Access type: 0 read, 1 write |
| lk_va | input | VA_W | Virtual address to translate |
| inst_en | input | 1 | Install strobe |
| inst_vpn | input | VA_W-OFS_W | Page number of the mapping to install |
| inst_ppn | input | PA_W-OFS_W | Physical page number to install |
| inst_rights | input | 2 | Rights field: bit 0 read, bit 1 write |
| flush | input | 1 | Invalidate all entries |
| clr_ref | input | 1 | Clear all reference bits |
| res_vld | output | 1 | Result present (one cycle after strobe) |
| res_hit | output | 1 | Permitted translation |
| res_miss | output | 1 | No matching entry: trap to software |
| res_fault | output | 1 | Matching entry without permission |
| res_dirty | output | 1 | Dirty bit of the hit entry before this access |
| res_pa | output | PA_W | Physical address on a hit, otherwise zero |

## Verification
The bench builds the block with SETS=4 and the default address widths, so the set index is 2 bits and the tag is 24 bits. With only four sets, two installs are enough to fill a set, so each branch of the way-selection rule can be reached in a few cycles. These branches are a matching page, an invalid way, a clear reference bit and the way-0 fallback. Reference-bit state is observed indirectly, through which entry a later install evicts. Dirty state is read back through `res_dirty` on a following hit.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int DEF_VA_W  = 40;
    localparam int DEF_PA_W  = 36;
    localparam int DEF_OFS_W = 14;
    localparam int DEF_SETS  = 128;
    localparam int DEF_WAYS  = 2;

    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } acc_e;

    // Status held per entry
    typedef struct packed {
        logic       valid;
        logic       dirty;
        logic       refd;
        logic [1:0] rights;
    } tlb_stat_t;

    // Registered lookup outcome
    typedef struct packed {
        logic vld;
        logic hit;
        logic miss;
        logic fault;
        logic dirty;
    } tlb_res_t;

    function automatic logic rights_ok(input logic [1:0] rights, input acc_e acc);
        return (acc == ACC_WRITE) ? rights[1] : rights[0];
    endfunction

endpackage

// File: rtl/tlb_way.sv
module tlb_way
    import tlb_pkg::*;
#(
    parameter int SETS  = DEF_SETS,
    parameter int TAG_W = 19,
    parameter int PPN_W = 22,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             clr_ref,
    // lookup read port and use update
    input  logic [IDX_W-1:0] lk_idx,
    output tlb_stat_t        lk_stat,
    output logic [TAG_W-1:0] lk_tag,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             touch_en,
    input  logic             touch_dirty,
    // install read and write port
    input  logic [IDX_W-1:0] in_idx,
    output tlb_stat_t        in_stat,
    output logic [TAG_W-1:0] in_tag,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic [1:0]       wr_rights
);

    logic [SETS-1:0]  vld_q;
    logic [SETS-1:0]  dty_q;
    logic [SETS-1:0]  ref_q;
    logic [1:0]       rgt_q [SETS];
    logic [TAG_W-1:0] tag_q [SETS];
    logic [PPN_W-1:0] ppn_q [SETS];

    // Later assignments take priority: install over use, flush over install
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            dty_q <= '0;
            ref_q <= '0;
        end else begin
            if (clr_ref) ref_q <= '0;
            if (touch_en) begin
                ref_q[lk_idx] <= 1'b1;
                if (touch_dirty) dty_q[lk_idx] <= 1'b1;
            end
            if (wr_en) begin
                vld_q[in_idx] <= 1'b1;
                dty_q[in_idx] <= 1'b0;
                ref_q[in_idx] <= 1'b0;
            end
            if (flush) vld_q <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !flush) begin
            rgt_q[in_idx] <= wr_rights;
            tag_q[in_idx] <= wr_tag;
            ppn_q[in_idx] <= wr_ppn;
        end
    end

    always_comb begin
        lk_stat = '{valid: vld_q[lk_idx], dirty: dty_q[lk_idx],
                    refd: ref_q[lk_idx], rights: rgt_q[lk_idx]};
        lk_tag  = tag_q[lk_idx];
        lk_ppn  = ppn_q[lk_idx];
        in_stat = '{valid: vld_q[in_idx], dirty: dty_q[in_idx],
                    refd: ref_q[in_idx], rights: rgt_q[in_idx]};
        in_tag  = tag_q[in_idx];
    end

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> (vld_q == '0)); // R8

    AST_REF_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (clr_ref && !touch_en) |=> (ref_q == '0)); // R9

    AST_INSTALL_FRESH: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !flush) |=> (vld_q[$past(in_idx)] && !ref_q[$past(in_idx)]
                               && !dty_q[$past(in_idx)])); // R6

    AST_USE_MARKS_REF: assert property (@(posedge clk) disable iff (rst)
        (touch_en && !wr_en) |=> ref_q[$past(lk_idx)]); // R4

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int WAYS = 2
) (
    input  logic [WAYS-1:0] match,
    input  logic [WAYS-1:0] valid,
    input  logic [WAYS-1:0] refd,
    output logic [WAYS-1:0] way_oh
);

    logic found;

    // Priority: same page, then lowest invalid, then lowest unreferenced, else way 0
    always_comb begin
        way_oh = '0;
        found  = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && match[w]) begin
                way_oh[w] = 1'b1;
                found     = 1'b1;
            end
        end
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !valid[w]) begin
                way_oh[w] = 1'b1;
                found     = 1'b1;
            end
        end
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !refd[w]) begin
                way_oh[w] = 1'b1;
                found     = 1'b1;
            end
        end
        if (!found) way_oh[0] = 1'b1;
    end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int VA_W  = DEF_VA_W,
    parameter int PA_W  = DEF_PA_W,
    parameter int OFS_W = DEF_OFS_W,
    parameter int SETS  = DEF_SETS,
    parameter int WAYS  = DEF_WAYS,
    localparam int VPN_W = VA_W - OFS_W,
    localparam int PPN_W = PA_W - OFS_W,
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = VPN_W - IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_vld,
    input  logic             lk_wr,
    input  logic [VA_W-1:0]  lk_va,
    input  logic             inst_en,
    input  logic [VPN_W-1:0] inst_vpn,
    input  logic [PPN_W-1:0] inst_ppn,
    input  logic [1:0]       inst_rights,
    input  logic             flush,
    input  logic             clr_ref,
    output logic             res_vld,
    output logic             res_hit,
    output logic             res_miss,
    output logic             res_fault,
    output logic             res_dirty,
    output logic [PA_W-1:0]  res_pa
);

    logic [IDX_W-1:0] lk_idx, in_idx;
    logic [TAG_W-1:0] lk_tag, in_tagc;
    acc_e             lk_acc;

    assign lk_idx  = lk_va[OFS_W +: IDX_W];
    assign lk_tag  = lk_va[VA_W-1 -: TAG_W];
    assign in_idx  = inst_vpn[IDX_W-1:0];
    assign in_tagc = inst_vpn[VPN_W-1 -: TAG_W];
    assign lk_acc  = lk_wr ? ACC_WRITE : ACC_READ;

    tlb_stat_t        way_lk_stat [WAYS];
    tlb_stat_t        way_in_stat [WAYS];
    logic [TAG_W-1:0] way_lk_tag  [WAYS];
    logic [TAG_W-1:0] way_in_tag  [WAYS];
    logic [PPN_W-1:0] way_lk_ppn  [WAYS];

    logic [WAYS-1:0] hit_w, in_match, in_valid, in_refd, way_oh, touch_w;
    logic            any_hit, acc_ok;
    logic [PPN_W-1:0] sel_ppn;
    logic [1:0]       sel_rgt;
    logic             sel_dty;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        tlb_way #(
            .SETS (SETS),
            .TAG_W(TAG_W),
            .PPN_W(PPN_W)
        ) u_way (
            .clk        (clk),
            .rst        (rst),
            .flush      (flush),
            .clr_ref    (clr_ref),
            .lk_idx     (lk_idx),
            .lk_stat    (way_lk_stat[w]),
            .lk_tag     (way_lk_tag[w]),
            .lk_ppn     (way_lk_ppn[w]),
            .touch_en   (touch_w[w]),
            .touch_dirty(lk_wr),
            .in_idx     (in_idx),
            .in_stat    (way_in_stat[w]),
            .in_tag     (way_in_tag[w]),
            .wr_en      (inst_en && way_oh[w]),
            .wr_tag     (in_tagc),
            .wr_ppn     (inst_ppn),
            .wr_rights  (inst_rights)
        );

        assign hit_w[w]    = way_lk_stat[w].valid && (way_lk_tag[w] == lk_tag);
        assign in_match[w] = way_in_stat[w].valid && (way_in_tag[w] == in_tagc);
        assign in_valid[w] = way_in_stat[w].valid;
        assign in_refd[w]  = way_in_stat[w].refd;
        assign touch_w[w]  = lk_vld && hit_w[w] && acc_ok;
    end

    tlb_victim #(.WAYS(WAYS)) u_victim (
        .match (in_match),
        .valid (in_valid),
        .refd  (in_refd),
        .way_oh(way_oh)
    );

    always_comb begin
        any_hit = 1'b0;
        sel_ppn = '0;
        sel_rgt = '0;
        sel_dty = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_w[w]) begin
                any_hit = 1'b1;
                sel_ppn = sel_ppn | way_lk_ppn[w];
                sel_rgt = sel_rgt | way_lk_stat[w].rights;
                sel_dty = sel_dty | way_lk_stat[w].dirty;
            end
        end
        acc_ok = rights_ok(sel_rgt, lk_acc);
    end

    tlb_res_t        res_q;
    logic [PA_W-1:0] pa_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            pa_q  <= '0;
        end else begin
            res_q.vld   <= lk_vld;
            res_q.hit   <= lk_vld && any_hit && acc_ok;
            res_q.miss  <= lk_vld && !any_hit;
            res_q.fault <= lk_vld && any_hit && !acc_ok;
            res_q.dirty <= lk_vld && any_hit && acc_ok && sel_dty;
            pa_q        <= (lk_vld && any_hit && acc_ok) ?
                           {sel_ppn, lk_va[OFS_W-1:0]} : '0;
        end
    end

    assign res_vld   = res_q.vld;
    assign res_hit   = res_q.hit;
    assign res_miss  = res_q.miss;
    assign res_fault = res_q.fault;
    assign res_dirty = res_q.dirty;
    assign res_pa    = pa_q;

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        res_vld |-> $onehot({res_hit, res_miss, res_fault})); // R2

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !res_vld |-> !(res_hit || res_miss || res_fault || res_dirty)); // R2

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
        res_hit |-> (res_pa[OFS_W-1:0] == $past(lk_va[OFS_W-1:0]))); // R1

    AST_NOHIT_ZERO_PA: assert property (@(posedge clk) disable iff (rst)
        !res_hit |-> (res_pa == '0)); // R3

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
        lk_vld |-> $onehot0(hit_w)); // R6

    AST_VICTIM_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        inst_en |-> $onehot(way_oh)); // R6

endmodule

// File: tb/tb_tlb_xlate.sv
`timescale 1ns/1ps
module tb_tlb_xlate;

    localparam int VA_W  = 40;
    localparam int PA_W  = 36;
    localparam int OFS_W = 14;
    localparam int SETS  = 4;
    localparam int IDX_W = 2;
    localparam int VPN_W = VA_W - OFS_W;
    localparam int PPN_W = PA_W - OFS_W;
    localparam int TAG_W = VPN_W - IDX_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             lk_vld = 1'b0, lk_wr = 1'b0;
    logic [VA_W-1:0]  lk_va = '0;
    logic             inst_en = 1'b0;
    logic [VPN_W-1:0] inst_vpn = '0;
    logic [PPN_W-1:0] inst_ppn = '0;
    logic [1:0]       inst_rights = '0;
    logic             flush = 1'b0, clr_ref = 1'b0;
    logic             res_vld, res_hit, res_miss, res_fault, res_dirty;
    logic [PA_W-1:0]  res_pa;

    always #2.5 clk = ~clk;

    tlb_xlate #(.VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W), .SETS(SETS)) dut (
        .clk(clk), .rst(rst), .lk_vld(lk_vld), .lk_wr(lk_wr), .lk_va(lk_va),
        .inst_en(inst_en), .inst_vpn(inst_vpn), .inst_ppn(inst_ppn),
        .inst_rights(inst_rights), .flush(flush), .clr_ref(clr_ref),
        .res_vld(res_vld), .res_hit(res_hit), .res_miss(res_miss),
        .res_fault(res_fault), .res_dirty(res_dirty), .res_pa(res_pa)
    );

    typedef struct {
        logic [3:0]      flags;   // hit, miss, fault, dirty
        logic [PA_W-1:0] pa;
        string           req;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;

    localparam int K_HIT = 0, K_MISS = 1, K_FAULT = 2;

    // Driver: called at a negedge, returns at the next negedge
    task automatic look(input logic [TAG_W-1:0] tg, input logic [IDX_W-1:0] ix,
                        input logic [OFS_W-1:0] off, input logic wr, input int kind,
                        input logic [PPN_W-1:0] ppn, input logic dty, input string req);
        exp_t e;
        e.flags = {kind == K_HIT, kind == K_MISS, kind == K_FAULT,
                   (kind == K_HIT) && dty};
        e.pa    = (kind == K_HIT) ? {ppn, off} : '0;
        e.req   = req;
        q.push_back(e);
        lk_vld = 1'b1;
        lk_wr  = wr;
        lk_va  = {tg, ix, off};
        @(negedge clk);
        lk_vld = 1'b0;
    endtask

    task automatic put(input logic [TAG_W-1:0] tg, input logic [IDX_W-1:0] ix,
                       input logic [PPN_W-1:0] ppn, input logic [1:0] rgt);
        inst_en     = 1'b1;
        inst_vpn    = {tg, ix};
        inst_ppn    = ppn;
        inst_rights = rgt;
        @(negedge clk);
        inst_en = 1'b0;
    endtask

    // Monitor: compares each result against the oldest expectation
    always @(negedge clk) begin
        if (!rst) begin
            if (res_vld) begin
                checks++;
                if (q.size() == 0) begin
                    errors++;
                    $display("FAIL R2: unexpected result, actual vld=%b expected vld=0", res_vld);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if ({res_hit, res_miss, res_fault, res_dirty} != e.flags || res_pa != e.pa) begin
                        errors++;
                        $display("FAIL %s: actual hmfd=%b pa=%h expected hmfd=%b pa=%h",
                                 e.req, {res_hit, res_miss, res_fault, res_dirty}, res_pa,
                                 e.flags, e.pa);
                    end
                end
            end
        end
    end

    task automatic check_idle(input string req);
        checks++;
        if ({res_vld, res_hit, res_miss, res_fault, res_dirty} != 5'b0 || res_pa != '0) begin
            errors++;
            $display("FAIL %s: actual flags=%b pa=%h expected flags=00000 pa=0", req,
                     {res_vld, res_hit, res_miss, res_fault, res_dirty}, res_pa);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual run unfinished, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_idle("R10 reset outputs");
        look(24'h7, 2'd0, 14'h0, 1'b0, K_MISS, '0, 1'b0, "R10 empty after reset");

        // R1 basic translation, R2 misses in other set / other tag
        put(24'h1, 2'd0, 22'h0ABCD, 2'b11);
        look(24'h1, 2'd0, 14'h1234, 1'b0, K_HIT, 22'h0ABCD, 1'b0, "R1 read hit");
        look(24'h1, 2'd1, 14'h1234, 1'b0, K_MISS, '0, 1'b0, "R2 other set miss");
        look(24'h2, 2'd0, 14'h0010, 1'b0, K_MISS, '0, 1'b0, "R2 other tag miss");
        // R5 dirty set by permitted write
        look(24'h1, 2'd0, 14'h0001, 1'b1, K_HIT, 22'h0ABCD, 1'b0, "R5 first write");
        look(24'h1, 2'd0, 14'h3FFF, 1'b0, K_HIT, 22'h0ABCD, 1'b1, "R5 dirty after write");

        // R3 rights: read-only and write-only pages
        put(24'h3, 2'd1, 22'h12345, 2'b01);
        look(24'h3, 2'd1, 14'h0100, 1'b1, K_FAULT, '0, 1'b0, "R3 write to read-only");
        look(24'h3, 2'd1, 14'h0100, 1'b0, K_HIT, 22'h12345, 1'b0, "R5 fault left dirty clear");
        put(24'h4, 2'd1, 22'h2AAAA, 2'b10);
        look(24'h4, 2'd1, 14'h0200, 1'b0, K_FAULT, '0, 1'b0, "R3 read of write-only");
        look(24'h4, 2'd1, 14'h0200, 1'b1, K_HIT, 22'h2AAAA, 1'b0, "R3 write permitted");
        look(24'h4, 2'd1, 14'h0204, 1'b1, K_HIT, 22'h2AAAA, 1'b1, "R5 second write dirty");

        // R7 install and lookup in the same cycle
        inst_en = 1'b1; inst_vpn = {24'h5, 2'd2}; inst_ppn = 22'h00555; inst_rights = 2'b11;
        look(24'h5, 2'd2, 14'h0042, 1'b0, K_MISS, '0, 1'b0, "R7 same-cycle lookup sees old");
        inst_en = 1'b0;
        look(24'h5, 2'd2, 14'h0042, 1'b0, K_HIT, 22'h00555, 1'b0, "R7 next-cycle hit");

        // R4/R6 reference-guided replacement in set 3
        put(24'h10, 2'd3, 22'h0A0A0, 2'b11);
        put(24'h11, 2'd3, 22'h0B0B0, 2'b11);
        look(24'h10, 2'd3, 14'h0, 1'b0, K_HIT, 22'h0A0A0, 1'b0, "R4 hit marks A");
        put(24'h12, 2'd3, 22'h0C0C0, 2'b01);
        look(24'h11, 2'd3, 14'h0, 1'b0, K_MISS, '0, 1'b0, "R6 unreferenced B evicted");
        look(24'h10, 2'd3, 14'h0, 1'b0, K_HIT, 22'h0A0A0, 1'b0, "R6 referenced A kept");
        look(24'h12, 2'd3, 14'h0, 1'b0, K_HIT, 22'h0C0C0, 1'b0, "R6 C installed");
        put(24'h13, 2'd3, 22'h0D0D0, 2'b11);
        look(24'h10, 2'd3, 14'h0, 1'b0, K_MISS, '0, 1'b0, "R6 all referenced evicts way 0");
        look(24'h13, 2'd3, 14'h0, 1'b0, K_HIT, 22'h0D0D0, 1'b0, "R6 D in way 0");
        look(24'h12, 2'd3, 14'h0, 1'b0, K_HIT, 22'h0C0C0, 1'b0, "R6 C kept");

        // R9 bulk clear, R4 fault leaves reference clear
        clr_ref = 1'b1; @(negedge clk); clr_ref = 1'b0;
        look(24'h12, 2'd3, 14'h0, 1'b1, K_FAULT, '0, 1'b0, "R3 write fault on C");
        look(24'h13, 2'd3, 14'h0, 1'b0, K_HIT, 22'h0D0D0, 1'b0, "R4 hit marks D");
        put(24'h14, 2'd3, 22'h0E0E0, 2'b11);
        look(24'h12, 2'd3, 14'h0, 1'b0, K_MISS, '0, 1'b0, "R4 R9 C unreferenced evicted");
        look(24'h14, 2'd3, 14'h0, 1'b0, K_HIT, 22'h0E0E0, 1'b0, "R6 E installed");
        look(24'h13, 2'd3, 14'h0, 1'b0, K_HIT, 22'h0D0D0, 1'b0, "R9 D kept");

        // R9 clear together with a hit: the hit's reference survives
        clr_ref = 1'b1;
        look(24'h14, 2'd3, 14'h0, 1'b0, K_HIT, 22'h0E0E0, 1'b0, "R9 hit during clear");
        clr_ref = 1'b0;
        put(24'h15, 2'd3, 22'h0F0F0, 2'b11);
        look(24'h13, 2'd3, 14'h0, 1'b0, K_MISS, '0, 1'b0, "R9 cleared D evicted");
        look(24'h14, 2'd3, 14'h0, 1'b0, K_HIT, 22'h0E0E0, 1'b0, "R9 E reference kept");
        look(24'h15, 2'd3, 14'h0, 1'b0, K_HIT, 22'h0F0F0, 1'b0, "R6 F installed");

        // R6 same page number overwrites its own way
        put(24'h1, 2'd0, 22'h11111, 2'b11);
        look(24'h1, 2'd0, 14'h0777, 1'b0, K_HIT, 22'h11111, 1'b0, "R6 overwrite same page");

        // R8 flush wins over same-cycle install
        flush = 1'b1; inst_en = 1'b1; inst_vpn = {24'h20, 2'd0}; inst_ppn = 22'h2; inst_rights = 2'b11;
        @(negedge clk);
        flush = 1'b0; inst_en = 1'b0;
        look(24'h1,  2'd0, 14'h0, 1'b0, K_MISS, '0, 1'b0, "R8 flushed set 0");
        look(24'h20, 2'd0, 14'h0, 1'b0, K_MISS, '0, 1'b0, "R8 install dropped");
        look(24'h5,  2'd2, 14'h0, 1'b0, K_MISS, '0, 1'b0, "R8 flushed set 2");
        look(24'h14, 2'd3, 14'h0, 1'b0, K_MISS, '0, 1'b0, "R8 flushed set 3");

        // R6 invalid way preferred over an unreferenced valid way
        put(24'h30, 2'd1, 22'h00030, 2'b11);
        put(24'h31, 2'd1, 22'h00031, 2'b11);
        look(24'h30, 2'd1, 14'h0005, 1'b0, K_HIT, 22'h00030, 1'b0, "R6 G kept by invalid way");
        look(24'h31, 2'd1, 14'h0006, 1'b0, K_HIT, 22'h00031, 1'b0, "R6 H in invalid way");

        repeat (3) @(negedge clk);
        check_idle("R2 no strobe no result");
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R2: actual %0d results missing, expected 0", q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule